// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block produces the column address of every beat of one read or write burst to a synchronous graphics DRAM row of 256 columns. A controller presents a start column, a burst length code, a wrap order and a one-cycle start request. From the next clock on, the block emits one column per clock with a valid strobe. It raises a last-beat flag on the final beat. Fixed-length bursts wrap inside their aligned window in either linear or interleaved order. A full-page burst walks the whole row and keeps wrapping until a stop request ends it.

Command issue, data capture, CAS-latency alignment and mode decoding sit outside the block. The length and order arrive already decoded. A stop request can cut any burst short. A new start presented on the final beat chains a fresh burst with no idle clock between them.

Top module: `burst_col_seq`

## Requirements
- R1: After reset, and on every cycle with no burst in progress, `valid_o` and `last_o` are 0 and `col_o` is 0.
- R2: A start request with no burst in progress is taken at the clock edge. The next cycle shows beat 0 with `valid_o`=1 and `col_o` equal to the start column. Each later clock advances one beat.
- R3: In linear order with burst length BL, the column bits above bit log2(BL)-1 stay equal to the start column. The low log2(BL) bits equal (start low bits + beat index) modulo BL.
- R4: In interleaved order (`order_i`=1) with BL of 2, 4 or 8, the upper bits stay equal to the start column. The low log2(BL) bits equal the start low bits XOR the beat index.
- R5: Length codes 0, 1, 2 and 3 give bursts of 1, 2, 4 and 8 beats. `last_o` is 1 on beat BL-1, and `valid_o` is 0 on the following cycle unless a new start was taken.
- R6: Codes 4 to 7 select a full-page burst. The column increments by one per beat, wraps from 255 to 0, and never raises `last_o` on its own.
- R7: When `stop_i` is 1 during a valid beat, `last_o` is 1 in that same cycle. No further beat of that burst follows.
- R8: A full-page burst uses linear order even when `order_i` was 1 at its start.
- R9: A start request in a cycle where `valid_o` and `last_o` are both 1 is taken. The next cycle shows beat 0 of the new burst, with no idle cycle between the two.
- R10: A start request during a valid beat that is not the last one is ignored. A stop request with no burst in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request to begin a burst |
| start_col_i | input | 8 | First column of the requested burst |
| len_code_i | input | 3 | Length code: 0..3 give 1/2/4/8 beats, 4..7 give full page |
| order_i | input | 1 | Wrap order: 0 linear, 1 interleaved |
| stop_i | input | 1 | Ends the running burst on the current beat |
| col_o | output | 8 | Column address of the current beat |
| valid_o | output | 1 | A burst beat is present this cycle |
| last_o | output | 1 | Current beat is the final beat of the burst |

## Verification
The bench builds the block with its default parameters: an 8-bit column, a longest fixed burst of 8 beats, a 3-bit length code and the interleaved variant enabled. This keeps the full 256-column row short enough that a full-page burst can be run past the 255-to-0 wrap and then stopped. It also makes every fixed length and both wrap orders reachable from the same instance. Chained bursts, a start and a stop on the same final beat, and stops mid-window all fall within a few hundred cycles.

// File: rtl/bcs_pkg.sv
package bcs_pkg;

   typedef enum logic {
      ORDER_LINEAR = 1'b0,
      ORDER_XOR    = 1'b1
   } order_e;

   localparam int unsigned BCS_DEF_COL_W      = 8;
   localparam int unsigned BCS_DEF_LEN_W      = 3;
   localparam int unsigned BCS_DEF_MAX_LOG_BL = 3;

endpackage

// File: rtl/bcs_len_decode.sv
module bcs_len_decode #(
   parameter int unsigned COL_W      = 8,
   parameter int unsigned LEN_W      = 3,
   parameter int unsigned MAX_LOG_BL = 3
) (
   input  logic [LEN_W-1:0] code_i,
   output logic             page_o,
   output logic [COL_W-1:0] mask_o
);

   localparam logic [LEN_W-1:0] LAST_FIXED = LEN_W'(MAX_LOG_BL);

   assign page_o = (code_i > LAST_FIXED);

   for (genvar b = 0; b < int'(COL_W); b++) begin : g_mask
      assign mask_o[b] = page_o || (32'(b) < 32'(code_i));
   end

endmodule

// File: rtl/bcs_addr_gen.sv
module bcs_addr_gen #(
   parameter int unsigned COL_W             = 8,
   parameter bit          ENABLE_INTERLEAVE = 1'b1
) (
   input  logic [COL_W-1:0] base_i,
   input  logic [COL_W-1:0] idx_i,
   input  logic [COL_W-1:0] mask_i,
   input  logic             xor_i,
   output logic [COL_W-1:0] addr_o
);

   logic [COL_W-1:0] lin_addr;
   logic [COL_W-1:0] sum;

   assign sum      = base_i + idx_i;
   assign lin_addr = (base_i & ~mask_i) | (sum & mask_i);

   if (ENABLE_INTERLEAVE) begin : g_xor
      logic [COL_W-1:0] xor_addr;
      assign xor_addr = base_i ^ (idx_i & mask_i);
      assign addr_o   = xor_i ? xor_addr : lin_addr;
   end else begin : g_lin_only
      logic unused_xor;
      assign unused_xor = xor_i;
      assign addr_o     = lin_addr;
   end

endmodule

// File: rtl/bcs_beat_ctrl.sv
module bcs_beat_ctrl #(
   parameter int unsigned COL_W = 8,
   parameter int unsigned LEN_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic [COL_W-1:0] start_col_i,
   input  logic [LEN_W-1:0] len_code_i,
   input  logic             order_i,
   input  logic             stop_i,
   input  logic             page_i,
   input  logic [COL_W-1:0] mask_i,
   output logic             active_o,
   output logic [COL_W-1:0] idx_o,
   output logic [COL_W-1:0] base_o,
   output logic [LEN_W-1:0] code_o,
   output logic             order_o,
   output logic             last_o
);

   logic             active_q;
   logic [COL_W-1:0] idx_q;
   logic [COL_W-1:0] base_q;
   logic [LEN_W-1:0] code_q;
   logic             order_q;
   logic             window_end;
   logic             accept;

   assign window_end = !page_i && (idx_q == mask_i);
   assign last_o     = active_q && (window_end || stop_i);
   assign accept     = start_i && (!active_q || last_o);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         idx_q    <= '0;
         base_q   <= '0;
         code_q   <= '0;
         order_q  <= 1'b0;
      end else if (accept) begin
         active_q <= 1'b1;
         idx_q    <= '0;
         base_q   <= start_col_i;
         code_q   <= len_code_i;
         order_q  <= order_i;
      end else if (last_o) begin
         active_q <= 1'b0;
      end else if (active_q) begin
         idx_q <= idx_q + 1'b1;
      end
   end

   assign active_o = active_q;
   assign idx_o    = idx_q;
   assign base_o   = base_q;
   assign code_o   = code_q;
   assign order_o  = order_q;

endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq #(
   parameter int unsigned COL_W             = bcs_pkg::BCS_DEF_COL_W,
   parameter int unsigned LEN_W             = bcs_pkg::BCS_DEF_LEN_W,
   parameter int unsigned MAX_LOG_BL        = bcs_pkg::BCS_DEF_MAX_LOG_BL,
   parameter bit          ENABLE_INTERLEAVE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic [COL_W-1:0] start_col_i,
   input  logic [LEN_W-1:0] len_code_i,
   input  logic             order_i,
   input  logic             stop_i,
   output logic [COL_W-1:0] col_o,
   output logic             valid_o,
   output logic             last_o
);

   if (COL_W <= MAX_LOG_BL) begin : g_bad_col_w
      $error("burst_col_seq: COL_W must exceed MAX_LOG_BL");
   end
   if (MAX_LOG_BL + 1 > (1 << LEN_W) - 1) begin : g_bad_len_w
      $error("burst_col_seq: LEN_W leaves no code for a full-page burst");
   end

   logic             active;
   logic [COL_W-1:0] idx;
   logic [COL_W-1:0] base;
   logic [LEN_W-1:0] code_q;
   logic             order_q;
   logic             page;
   logic [COL_W-1:0] mask;
   logic             use_xor;
   logic [COL_W-1:0] addr;

   bcs_len_decode #(
      .COL_W      (COL_W),
      .LEN_W      (LEN_W),
      .MAX_LOG_BL (MAX_LOG_BL)
   ) u_dec (
      .code_i (code_q),
      .page_o (page),
      .mask_o (mask)
   );

   bcs_beat_ctrl #(
      .COL_W (COL_W),
      .LEN_W (LEN_W)
   ) u_ctrl (
      .clk         (clk),
      .rst_n       (rst_n),
      .start_i     (start_i),
      .start_col_i (start_col_i),
      .len_code_i  (len_code_i),
      .order_i     (order_i),
      .stop_i      (stop_i),
      .page_i      (page),
      .mask_i      (mask),
      .active_o    (active),
      .idx_o       (idx),
      .base_o      (base),
      .code_o      (code_q),
      .order_o     (order_q),
      .last_o      (last_o)
   );

   assign use_xor = (bcs_pkg::order_e'(order_q) == bcs_pkg::ORDER_XOR) && !page;

   bcs_addr_gen #(
      .COL_W             (COL_W),
      .ENABLE_INTERLEAVE (ENABLE_INTERLEAVE)
   ) u_addr (
      .base_i (base),
      .idx_i  (idx),
      .mask_i (mask),
      .xor_i  (use_xor),
      .addr_o (addr)
   );

   assign valid_o = active;
   assign col_o   = active ? addr : '0;

endmodule

// File: rtl/bcs_checker.sv
module bcs_checker #(
   parameter int unsigned COL_W      = 8,
   parameter int unsigned LEN_W      = 3,
   parameter int unsigned MAX_LOG_BL = 3
) (
   input logic             clk,
   input logic             rst_n,
   input logic             start_i,
   input logic [COL_W-1:0] start_col_i,
   input logic [LEN_W-1:0] len_code_i,
   input logic             order_i,
   input logic             stop_i,
   input logic [COL_W-1:0] col_o,
   input logic             valid_o,
   input logic             last_o
);

   logic             taken;
   logic             req_page;
   logic [COL_W-1:0] req_mask;
   logic [COL_W-1:0] ck_mask;
   logic             ck_linear;

   assign taken    = start_i && (!valid_o || last_o);
   assign req_page = (32'(len_code_i) > MAX_LOG_BL);

   always_comb begin
      for (int b = 0; b < int'(COL_W); b++) begin
         req_mask[b] = req_page || (b < int'(len_code_i));
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ck_mask   <= '0;
         ck_linear <= 1'b1;
      end else if (taken) begin
         ck_mask   <= req_mask;
         ck_linear <= !order_i || req_page;
      end
   end

   assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !valid_o |-> (col_o == '0) && !last_o);

   assert_start_beat0_R2: assert property (@(posedge clk) disable iff (!rst_n)
      taken |=> valid_o && (col_o == $past(start_col_i)));

   assert_upper_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o && !last_o |=> (((col_o ^ $past(col_o)) & ~ck_mask) == '0));

   assert_linear_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o && !last_o && ck_linear |=> ((col_o & ck_mask) == (($past(col_o) + 1'b1) & ck_mask)));

   assert_end_drops_R5: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o && last_o && !start_i |=> !valid_o);

   assert_keep_going_R6: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o && !last_o |=> valid_o);

   assert_stop_ends_R7: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o && stop_i |-> last_o);

endmodule

bind burst_col_seq bcs_checker #(
   .COL_W      (COL_W),
   .LEN_W      (LEN_W),
   .MAX_LOG_BL (MAX_LOG_BL)
) u_bcs_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .start_i     (start_i),
   .start_col_i (start_col_i),
   .len_code_i  (len_code_i),
   .order_i     (order_i),
   .stop_i      (stop_i),
   .col_o       (col_o),
   .valid_o     (valid_o),
   .last_o      (last_o)
);

// File: tb/sim_burst_col_seq.sv
`timescale 1ns/1ps
module sim_burst_col_seq;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start_i = 1'b0;
   logic [7:0] start_col_i = '0;
   logic [2:0] len_code_i = '0;
   logic       order_i = 1'b0;
   logic       stop_i = 1'b0;
   logic [7:0] col_o;
   logic       valid_o;
   logic       last_o;

   int checks = 0;
   int fails  = 0;

   int m_active = 0;
   int m_beat   = 0;
   int m_base   = 0;
   int m_bl     = 0;
   int m_xor    = 0;

   always #5 clk = ~clk;

   burst_col_seq u0 (
      .clk         (clk),
      .rst_n       (rst_n),
      .start_i     (start_i),
      .start_col_i (start_col_i),
      .len_code_i  (len_code_i),
      .order_i     (order_i),
      .stop_i      (stop_i),
      .col_o       (col_o),
      .valid_o     (valid_o),
      .last_o      (last_o)
   );

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   endtask

   task automatic check(string tag, string what, int act, int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h at %0t", tag, what, act, exp, $time);
      end
   endtask

   // Drive one cycle, compare against the model, then advance the model.
   task automatic step(bit s, int c, int code, bit ord, bit stp, string tag);
      int e_col, e_last, blk, lo;
      @(negedge clk);
      start_i     = s;
      start_col_i = 8'(c);
      len_code_i  = 3'(code);
      order_i     = ord;
      stop_i      = stp;
      #1;
      e_col  = 0;
      e_last = 0;
      if (m_active != 0) begin
         if (m_bl == 0) begin
            e_col = (m_base + m_beat) % 256;
         end else begin
            blk = (m_base / m_bl) * m_bl;
            lo  = m_base % m_bl;
            e_col = (m_xor != 0) ? blk + (lo ^ m_beat) : blk + ((lo + m_beat) % m_bl);
         end
         e_last = ((m_bl != 0 && m_beat == m_bl - 1) || stp) ? 1 : 0;
      end
      check(tag, "valid_o", int'(valid_o), m_active);
      check(tag, "col_o", int'(col_o), e_col);
      check(tag, "last_o", int'(last_o), e_last);
      if (rst_n && s && (m_active == 0 || e_last != 0)) begin
         m_active = 1;
         m_beat   = 0;
         m_base   = c;
         m_bl     = (code <= 3) ? (1 << code) : 0;
         m_xor    = (m_bl > 1 && ord) ? 1 : 0;
      end else if (m_active != 0 && e_last != 0) begin
         m_active = 0;
      end else if (m_active != 0) begin
         m_beat = (m_beat + 1) % 256;
      end
   endtask

   task automatic idle(int n, string tag);
      for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, tag);
   endtask

   initial begin
      #2_000_000;
      fails++;
      checks++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      finish_run();
   end

   initial begin
      // R1: reset and idle state
      idle(3, "R1");
      @(negedge clk);
      rst_n = 1'b1;
      idle(2, "R1");

      // R2 R3: linear length 4 from 0x16 -> 16 17 14 15
      step(1, 'h16, 2, 0, 0, "R2");
      idle(4, "R3");
      idle(1, "R5");

      // R4: interleaved length 8 from 0x2B
      step(1, 'h2B, 3, 1, 0, "R4");
      idle(8, "R4");
      idle(1, "R5");

      // R5: single beat burst
      step(1, 'h77, 0, 0, 0, "R5");
      idle(2, "R5");

      // R4: interleaved length 2 from 0x01 -> 01 00
      step(1, 'h01, 1, 1, 0, "R4");
      idle(3, "R4");

      // R3: linear length 8 from 0xC5
      step(1, 'hC5, 3, 0, 0, "R3");
      idle(9, "R3");

      // R6: full page from 0xFD, past a complete wrap, then stop (R7)
      step(1, 'hFD, 4, 0, 0, "R6");
      idle(300, "R6");
      step(0, 0, 0, 0, 1, "R7");
      idle(2, "R7");

      // R8: code 7 with interleave requested still walks linearly
      step(1, 'h35, 7, 1, 0, "R8");
      idle(6, "R8");
      step(0, 0, 0, 0, 1, "R8");
      idle(1, "R8");

      // R7: stop a length-8 burst on beat 2
      step(1, 'h40, 3, 0, 0, "R7");
      idle(2, "R7");
      step(0, 0, 0, 0, 1, "R7");
      idle(2, "R7");

      // R9: chained bursts with no gap
      step(1, 'h10, 2, 0, 0, "R9");
      idle(3, "R9");
      step(1, 'h83, 1, 1, 0, "R9");
      idle(1, "R9");
      step(1, 'h05, 0, 0, 0, "R9");
      idle(2, "R9");

      // R9: start and stop together on a full-page beat, start wins
      step(1, 'hA0, 5, 0, 0, "R9");
      idle(2, "R9");
      step(1, 'h3C, 2, 1, 1, "R9");
      idle(5, "R9");

      // R10: start mid-burst ignored, stop while idle ignored
      step(1, 'h60, 3, 0, 0, "R10");
      idle(1, "R10");
      step(1, 'hAA, 0, 0, 0, "R10");
      idle(7, "R10");
      step(0, 0, 0, 0, 1, "R10");
      idle(2, "R10");

      finish_run();
   end

endmodule